// File: doc/BRIEF.md
# USB Buffer Descriptor Locator

This block sits next to the packet engine of a USB device controller with sixteen endpoints. It holds one Even/Odd selector bit for each endpoint and direction, and it turns an endpoint number, a direction and that selector into the position of the matching buffer descriptor. It returns that position both as a descriptor index and as a byte address in the descriptor table. The table starts at byte 0x400, and each descriptor is four bytes long.

A two-bit buffering setting decides which endpoint directions have a pair of descriptors and which have only one. With no pairing, every direction has one descriptor. In the second setting, only endpoint 0 OUT is paired, so every descriptor after it moves up one slot. In the third setting, every direction is paired.

When the engine reports a finished transaction, the selector for that endpoint direction flips. The block also records whether that transaction used the Even or the Odd descriptor. A clear request sends all selectors back to Even. Disabling the module holds all of them at Even.

Top module: `usb_bd_locator`

## Requirements
- R1: After reset, and while `enable` is low, every selector is Even and `last_odd` reads 0.
- R2: When `buf_mode` is 00 or 11, `bd_index` = 2*`lookup_ep` + `lookup_in`, where OUT is 0 and IN is 1. The selector has no effect.
- R3: When `buf_mode` is 01, endpoint 0 OUT gives `bd_index` = selector (0 for Even, 1 for Odd). Every other direction gives 2*ep + dir + 1.
- R4: When `buf_mode` is 10, `bd_index` = 4*ep + 2*dir + selector.
- R5: `bd_addr` = 0x400 + 4*`bd_index`. It is combinational, like `bd_index`.
- R6: When `xfer_done` is high on a paired endpoint direction, with `enable` high and `clr_ptrs` low, that direction's selector flips at the next clock edge. No other selector changes.
- R7: In that case, `last_odd` shows the selector value from before the flip (1 = Odd), starting from the cycle after the strobe.
- R8: When `xfer_done` is high on an unpaired direction, its selector does not change and `last_odd` becomes 0.
- R9: When `clr_ptrs` is high with `enable` high, every selector returns to Even at the next clock edge. This overrides a `xfer_done` in the same cycle, and `last_odd` keeps its value.
- R10: While `enable` is low, `xfer_done` is ignored.

Selectors keep their values when `buf_mode` changes while the module is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Module enable; low clears the state |
| buf_mode | input | 2 | Buffering setting: 00 none, 01 EP0 OUT only, 10 all, 11 same as 00 |
| clr_ptrs | input | 1 | Returns every selector to Even |
| xfer_done | input | 1 | Transaction-complete strobe |
| done_ep | input | 4 | Endpoint of the finished transaction |
| done_in | input | 1 | Direction of the finished transaction (1 = IN) |
| lookup_ep | input | 4 | Endpoint to locate |
| lookup_in | input | 1 | Direction to locate (1 = IN) |
| bd_index | output | 6 | Descriptor index |
| bd_addr | output | 16 | Descriptor byte address |
| last_odd | output | 1 | Even (0) or Odd (1) of the last finished transaction |

## Verification
The assertions assume that `buf_mode` carries only the four defined codes. They also assume that `clr_ptrs` and `xfer_done` are sampled only at clock edges, so that at most one selector can flip per cycle.

The stimulus changes all inputs on the falling edge and raises `xfer_done` for a single cycle at a time. It changes `buf_mode` and `enable` only while no strobe is pending. The lookup inputs are swept across all 32 endpoint directions, and all four mode codes are used.

// File: rtl/usb_bd_pkg.sv
package usb_bd_pkg;

    typedef enum logic [1:0] {
        BUF_NONE    = 2'b00,
        BUF_EP0_OUT = 2'b01,
        BUF_ALL     = 2'b10,
        BUF_RSVD    = 2'b11
    } buf_mode_e;

    // True when the endpoint direction owns a descriptor pair in this mode.
    function automatic logic slot_is_double(buf_mode_e m, logic slot_zero);
        case (m)
            BUF_ALL:     return 1'b1;
            BUF_EP0_OUT: return slot_zero;
            default:     return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/usb_pp_bank.sv
module usb_pp_bank
    import usb_bd_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  buf_mode_e            mode,
    input  logic                 clr_ptrs,
    input  logic                 done_valid,
    input  logic [SLOT_W-1:0]    done_slot,
    output logic [NUM_SLOTS-1:0] ptr_vec,
    output logic                 last_odd
);

    typedef struct packed {
        logic [NUM_SLOTS-1:0] ptr;
        logic                 last_odd;
    } bank_t;

    bank_t st_d, st_q;
    logic  done_dbl;

    assign done_dbl = slot_is_double(mode, done_slot == '0);

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d.ptr      = '0;
            st_d.last_odd = 1'b0;
        end else if (clr_ptrs) begin
            st_d.ptr = '0;
        end else if (done_valid) begin
            if (done_dbl) begin
                st_d.last_odd       = st_q.ptr[done_slot];
                st_d.ptr[done_slot] = ~st_q.ptr[done_slot];
            end else begin
                st_d.last_odd = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_vec  = st_q.ptr;
    assign last_odd = st_q.last_odd;

    assert_off_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (ptr_vec == '0 && !last_odd));

    assert_clr_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && clr_ptrs) |=> (ptr_vec == '0 && $stable(last_odd)));

    assert_one_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !clr_ptrs) |=> ($countones(ptr_vec ^ $past(ptr_vec)) <= 1));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !clr_ptrs && !done_valid) |=> ($stable(ptr_vec) && $stable(last_odd)));

    assert_single_even_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !clr_ptrs && done_valid && !done_dbl) |=> ($stable(ptr_vec) && !last_odd));

endmodule

// File: rtl/usb_bd_map.sv
module usb_bd_map
    import usb_bd_pkg::*;
#(
    parameter int NUM_EP   = 16,
    parameter int ADDR_W   = 16,
    parameter int BD_BASE  = 'h400,
    parameter int BD_BYTES = 4,
    localparam int SLOT_W  = $clog2(2 * NUM_EP),
    localparam int IDX_W   = $clog2(4 * NUM_EP)
) (
    input  buf_mode_e         mode,
    input  logic [SLOT_W-1:0] slot,
    input  logic              ptr_bit,
    output logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);

    logic [IDX_W-1:0] slot_w;

    assign slot_w = IDX_W'(slot);

    always_comb begin
        case (mode)
            BUF_ALL:     idx = {slot_w[IDX_W-2:0], ptr_bit};
            BUF_EP0_OUT: idx = (slot == '0) ? IDX_W'(ptr_bit) : slot_w + IDX_W'(1);
            default:     idx = slot_w;
        endcase
    end

    assign addr = ADDR_W'(BD_BASE) + ADDR_W'(idx) * ADDR_W'(BD_BYTES);

endmodule

// File: rtl/usb_bd_locator.sv
module usb_bd_locator
    import usb_bd_pkg::*;
#(
    parameter int NUM_EP   = 16,
    parameter int ADDR_W   = 16,
    parameter int BD_BASE  = 'h400,
    parameter int BD_BYTES = 4,
    localparam int EP_W    = $clog2(NUM_EP),
    localparam int SLOTS   = 2 * NUM_EP,
    localparam int SLOT_W  = $clog2(SLOTS),
    localparam int IDX_W   = $clog2(4 * NUM_EP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [1:0]        buf_mode,
    input  logic              clr_ptrs,
    input  logic              xfer_done,
    input  logic [EP_W-1:0]   done_ep,
    input  logic              done_in,
    input  logic [EP_W-1:0]   lookup_ep,
    input  logic              lookup_in,
    output logic [IDX_W-1:0]  bd_index,
    output logic [ADDR_W-1:0] bd_addr,
    output logic              last_odd
);

    buf_mode_e         mode;
    logic [SLOTS-1:0]  ptr_vec;
    logic [SLOT_W-1:0] lookup_slot;
    logic [SLOT_W-1:0] done_slot;

    assign mode        = buf_mode_e'(buf_mode);
    assign lookup_slot = {lookup_ep, lookup_in};
    assign done_slot   = {done_ep, done_in};

    usb_pp_bank #(
        .NUM_SLOTS (SLOTS)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .mode       (mode),
        .clr_ptrs   (clr_ptrs),
        .done_valid (xfer_done),
        .done_slot  (done_slot),
        .ptr_vec    (ptr_vec),
        .last_odd   (last_odd)
    );

    usb_bd_map #(
        .NUM_EP   (NUM_EP),
        .ADDR_W   (ADDR_W),
        .BD_BASE  (BD_BASE),
        .BD_BYTES (BD_BYTES)
    ) u_map (
        .mode    (mode),
        .slot    (lookup_slot),
        .ptr_bit (ptr_vec[lookup_slot]),
        .idx     (bd_index),
        .addr    (bd_addr)
    );

    assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != BUF_ALL) |-> (bd_index <= IDX_W'(SLOTS)));

    assert_single_ignores_ptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == BUF_NONE || mode == BUF_RSVD) |-> (bd_index == IDX_W'(lookup_slot)));

endmodule

// File: tb/tb_usb_bd_locator.sv
module tb_usb_bd_locator;

    logic        clk = 1'b0;
    logic        rst_n, enable, clr_ptrs, xfer_done, done_in, lookup_in;
    logic [1:0]  buf_mode;
    logic [3:0]  done_ep, lookup_ep;
    logic [5:0]  bd_index;
    logic [15:0] bd_addr;
    logic        last_odd;

    int checks = 0;
    int errors = 0;
    bit m_ptr [32];
    bit m_st;

    always #5 clk = ~clk;

    usb_bd_locator dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .buf_mode(buf_mode),
        .clr_ptrs(clr_ptrs), .xfer_done(xfer_done), .done_ep(done_ep),
        .done_in(done_in), .lookup_ep(lookup_ep), .lookup_in(lookup_in),
        .bd_index(bd_index), .bd_addr(bd_addr), .last_odd(last_odd)
    );

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit is_dbl(int m, int s);
        return (m == 2) || (m == 1 && s == 0);
    endfunction

    function automatic int exp_idx(int m, int s, bit p);
        if (m == 2) return 2 * s + p;
        if (m == 1) return (s == 0) ? p : s + 1;
        return s;
    endfunction

    task automatic sweep();
        for (int s = 0; s < 32; s++) begin
            int e;
            string tag;
            @(negedge clk);
            lookup_ep = 4'(s >> 1);
            lookup_in = s[0];
            #1;
            e = exp_idx(buf_mode, s, m_ptr[s]);
            tag = (buf_mode == 2) ? "R4/R6" : (buf_mode == 1) ? "R3/R6" : "R2";
            check(bd_index == 6'(e), tag, bd_index, e);
            check(bd_addr == 16'('h400 + 4 * e), "R5", bd_addr, 'h400 + 4 * e);
        end
    endtask

    task automatic strobe(int s, bit clr, string req);
        @(negedge clk);
        xfer_done = 1'b1;
        done_ep   = 4'(s >> 1);
        done_in   = s[0];
        clr_ptrs  = clr;
        @(negedge clk);
        xfer_done = 1'b0;
        clr_ptrs  = 1'b0;
        if (!enable) begin
            foreach (m_ptr[i]) m_ptr[i] = 1'b0;
            m_st = 1'b0;
        end else if (clr) begin
            foreach (m_ptr[i]) m_ptr[i] = 1'b0;
        end else if (is_dbl(buf_mode, s)) begin
            m_st = m_ptr[s];
            m_ptr[s] = ~m_ptr[s];
        end else begin
            m_st = 1'b0;
        end
        #1;
        check(last_odd == m_st, req, last_odd, m_st);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; enable = 1'b0; buf_mode = 2'b10; clr_ptrs = 1'b0;
        xfer_done = 1'b0; done_ep = '0; done_in = 1'b0;
        lookup_ep = '0; lookup_in = 1'b0;
        foreach (m_ptr[i]) m_ptr[i] = 1'b0;
        m_st = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(last_odd == 1'b0, "R1", last_odd, 0);
        sweep();  // R1: all selectors Even under reset
        @(negedge clk);
        rst_n = 1'b1;
        enable = 1'b1;

        // R6/R7: toggling in the all-paired mode
        for (int k = 0; k < 48; k++) begin
            strobe((k * 7 + 3) % 32, 1'b0, "R7");
            sweep();
        end

        // R9: clear beats a same-cycle strobe, status held
        strobe(9, 1'b1, "R9");
        sweep();
        strobe(9, 1'b0, "R7");
        strobe(9, 1'b0, "R7");

        // R3: only endpoint 0 OUT paired
        buf_mode = 2'b01;
        for (int k = 0; k < 3; k++) begin
            strobe(0, 1'b0, "R7");
            sweep();
        end
        strobe(4, 1'b0, "R8");
        sweep();

        // R2/R8: unpaired modes, strobes leave selectors alone
        buf_mode = 2'b00;
        strobe(6, 1'b0, "R8");
        sweep();
        buf_mode = 2'b11;
        strobe(0, 1'b0, "R8");
        strobe(31, 1'b0, "R8");
        sweep();
        buf_mode = 2'b10;
        sweep();

        // R10/R1: disabled module ignores strobes and holds Even
        enable = 1'b0;
        strobe(2, 1'b0, "R10");
        sweep();
        enable = 1'b1;
        sweep();
        strobe(2, 1'b0, "R7");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule